// File: doc/BRIEF.md
# Hardware Thread Issue Scheduler

This block decides which hardware thread may place an instruction into a shared single-issue pipeline in each clock cycle. It does not store program counters or registers. It only names a thread, says whether that thread really issues, and flags the cycle as empty when nothing issues. The chosen thread number then travels down a short tag pipeline, one stage per cycle. Each pipeline stage can use it to reach that thread's state.

There are three scheduling policies, and they form the states of a small state machine:

- **SCH_FIXED**: strict rotation over the threads.
- **SCH_TABLE**: a rotation over a slot table that software writes.
- **SCH_READY**: a ready-driven choice with rotating priority.

A slot counter steps through the S table positions in every state. A request for another policy is taken only when that counter wraps. Table writes are also held in a pending copy until the wrap. The transitions are SCH_FIXED→SCH_TABLE, SCH_FIXED→SCH_READY, SCH_TABLE→SCH_FIXED, SCH_TABLE→SCH_READY, SCH_READY→SCH_FIXED and SCH_READY→SCH_TABLE, plus a self-loop on each state. Every transition happens only at a wrap. Reset returns the machine to SCH_FIXED.

Top module: `mt_issue_sched`

## Requirements
- R1: In SCH_FIXED the offered thread number increases by one each cycle and wraps from N-1 to 0. After the machine enters SCH_FIXED from another state, the first offered thread is 0. The mode request code 0 selects SCH_FIXED, and the code 3 is also treated as SCH_FIXED.
- R2: In SCH_FIXED and SCH_TABLE, the thread that owns the slot issues only when its bit in `thr_ready` is 1. If that bit is 0, `issue_valid` is 0 and `issue_tid` still names the owner, even when other threads are ready.
- R3: The slot index starts at 0 after reset, steps by one each cycle through 0..S-1 and then returns to 0. In SCH_TABLE (request code 1), `issue_tid` is the committed table entry at the current slot index.
- R4: In SCH_READY (request code 2), the grant goes to the first ready thread found by searching upward, with wrap-around, from a priority pointer. After a grant, the pointer moves to the granted thread plus one, modulo N. If no thread is ready, `issue_valid` is 0, `issue_tid` shows the pointer, and the pointer stays where it is.
- R5: Mode requests and table writes have no effect until the cycle in which the slot index is S-1. From the following cycle they apply. A table write made in that same cycle is part of the committed table.
- R6: Stage k of the tag pipeline (k = 0..NSTAGE-1) holds the `issue_valid` and `issue_tid` of the cycle k+1 cycles earlier. Empty cycles travel down the pipeline as invalid entries.
- R7: A synchronous active-high reset has these effects: the slot index, the fixed-rotation pointer and the priority pointer become 0; every tag stage becomes invalid with thread 0; both table copies are cleared to 0; and the state becomes SCH_FIXED.
- R8: `issue_bubble` is always the complement of `issue_valid`.
- R9: In SCH_FIXED with N threads, no thread number issued in a cycle appears in any of the N-1 previous issue cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | NTHR | Ready flag for each thread |
| mode_req | input | 2 | Requested policy: 0 fixed, 1 table, 2 ready, 3 fixed |
| tbl_wr_en | input | 1 | Write enable for the pending slot table |
| tbl_wr_slot | input | SLOT_W | Table position to write |
| tbl_wr_tid | input | TID_W | Thread number to store |
| issue_valid | output | 1 | The offered thread issues this cycle |
| issue_tid | output | TID_W | Offered thread number |
| issue_bubble | output | 1 | No issue this cycle |
| stage_vld | output | NSTAGE | Valid bit of each tag stage |
| stage_tid | output | NSTAGE*TID_W | Thread number of each tag stage, with stage k at bits k*TID_W upward |

## Verification
Two events can fall in the same cycle: the slot-counter wrap that commits the pending table, and a software write to the table. The stimulus table writes entry 7 while the slot index is 7, which is the wrap cycle. The written thread number must then appear in slot 7 of the following table-mode frame, and the earlier cleared value must not. A state change also coincides with the wrap. Policy requests are held steady for a whole frame, and the bench checks that the old policy stays in force up to slot S-1 and the new policy takes over exactly one cycle later. A table write made in the middle of a frame must stay invisible until the next wrap.

// File: rtl/mt_sched_pkg.sv
package mt_sched_pkg;

    typedef enum logic [1:0] {
        SCH_FIXED = 2'd0,
        SCH_TABLE = 2'd1,
        SCH_READY = 2'd2
    } sched_state_e;

    // Request code 3 has no policy of its own and falls back to rotation.
    function automatic sched_state_e decode_mode(input logic [1:0] code);
        sched_state_e res;
        case (code)
            2'd1:    res = SCH_TABLE;
            2'd2:    res = SCH_READY;
            default: res = SCH_FIXED;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/mt_slot_table.sv
module mt_slot_table #(
    parameter int NTHR  = 4,
    parameter int NSLOT = 8,
    localparam int TID_W  = (NTHR  > 1) ? $clog2(NTHR)  : 1,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic              commit,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [TID_W-1:0]  rd_tid
);

    logic [TID_W-1:0] pend_q [NSLOT];
    logic [TID_W-1:0] live_q [NSLOT];
    logic [TID_W-1:0] pend_d [NSLOT];

    // Next pending image: a write in the commit cycle is included.
    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_ent
            assign pend_d[g] = (wr_en && (wr_slot == SLOT_W'(g))) ? wr_tid : pend_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) begin
                pend_q[i] <= '0;
                live_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                pend_q[i] <= pend_d[i];
                if (commit) begin
                    live_q[i] <= pend_d[i];
                end
            end
        end
    end

    assign rd_tid = live_q[rd_slot];

endmodule

// File: rtl/mt_ready_arb.sv
module mt_ready_arb #(
    parameter int NTHR = 4,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic [NTHR-1:0]  req,
    input  logic [TID_W-1:0] start,
    output logic             hit,
    output logic [TID_W-1:0] grant_tid
);

    // Search upward from the pointer with wrap-around; the first request wins.
    always_comb begin
        hit       = 1'b0;
        grant_tid = '0;
        for (int i = 0; i < NTHR; i++) begin
            int idx;
            idx = (int'(start) + i) % NTHR;
            if (!hit && req[idx]) begin
                hit       = 1'b1;
                grant_tid = TID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/mt_tag_pipe.sv
module mt_tag_pipe #(
    parameter int NTHR   = 4,
    parameter int NSTAGE = 5,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [TID_W-1:0]        in_tid,
    output logic [NSTAGE-1:0]       stage_vld,
    output logic [NSTAGE*TID_W-1:0] stage_tid
);

    genvar k;
    generate
        for (k = 0; k < NSTAGE; k++) begin : g_stg
            logic             v_q;
            logic [TID_W-1:0] t_q;
            logic             v_in;
            logic [TID_W-1:0] t_in;

            if (k == 0) begin : g_head
                assign v_in = in_vld;
                assign t_in = in_tid;
            end else begin : g_body
                assign v_in = stage_vld[k-1];
                assign t_in = stage_tid[(k-1)*TID_W +: TID_W];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                    t_q <= '0;
                end else begin
                    v_q <= v_in;
                    t_q <= t_in;
                end
            end

            assign stage_vld[k]                 = v_q;
            assign stage_tid[k*TID_W +: TID_W] = t_q;
        end
    endgenerate

endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched
    import mt_sched_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int NSLOT  = 8,
    parameter int NSTAGE = 5,
    localparam int TID_W  = (NTHR  > 1) ? $clog2(NTHR)  : 1,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NTHR-1:0]         thr_ready,
    input  logic [1:0]              mode_req,
    input  logic                    tbl_wr_en,
    input  logic [SLOT_W-1:0]       tbl_wr_slot,
    input  logic [TID_W-1:0]        tbl_wr_tid,
    output logic                    issue_valid,
    output logic [TID_W-1:0]        issue_tid,
    output logic                    issue_bubble,
    output logic [NSTAGE-1:0]       stage_vld,
    output logic [NSTAGE*TID_W-1:0] stage_tid
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);
    localparam logic [TID_W-1:0]  LAST_TID  = TID_W'(NTHR - 1);

    sched_state_e      cur_state;
    sched_state_e      nxt_state;
    logic [SLOT_W-1:0] slot_idx;
    logic              slot_wrap;
    logic [TID_W-1:0]  fix_ptr;
    logic [TID_W-1:0]  rr_ptr;
    logic [TID_W-1:0]  tbl_tid;
    logic [TID_W-1:0]  arb_tid;
    logic              arb_hit;
    logic              sel_ok;
    logic [TID_W-1:0]  sel_tid;

    function automatic logic [TID_W-1:0] tid_inc(input logic [TID_W-1:0] t);
        return (t == LAST_TID) ? '0 : t + TID_W'(1);
    endfunction

    assign slot_wrap = (slot_idx == LAST_SLOT);
    assign nxt_state = decode_mode(mode_req);

    // State register: moves only on the slot wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= SCH_FIXED;
        end else if (slot_wrap) begin
            cur_state <= nxt_state;
        end
    end

    // Slot index runs in every state.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_idx <= '0;
        end else if (slot_wrap) begin
            slot_idx <= '0;
        end else begin
            slot_idx <= slot_idx + SLOT_W'(1);
        end
    end

    // Rotation pointer restarts at 0 on entry into fixed rotation.
    always_ff @(posedge clk) begin
        if (rst) begin
            fix_ptr <= '0;
        end else if (slot_wrap && (nxt_state == SCH_FIXED) && (cur_state != SCH_FIXED)) begin
            fix_ptr <= '0;
        end else if (cur_state == SCH_FIXED) begin
            fix_ptr <= tid_inc(fix_ptr);
        end
    end

    // Priority pointer follows the last ready-mode grant.
    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if ((cur_state == SCH_READY) && arb_hit) begin
            rr_ptr <= tid_inc(arb_tid);
        end
    end

    // Output process: one choice per state.
    always_comb begin
        sel_ok  = 1'b0;
        sel_tid = '0;
        unique case (cur_state)
            SCH_FIXED: begin
                sel_tid = fix_ptr;
                sel_ok  = thr_ready[fix_ptr];
            end
            SCH_TABLE: begin
                sel_tid = tbl_tid;
                sel_ok  = thr_ready[tbl_tid];
            end
            SCH_READY: begin
                sel_tid = arb_hit ? arb_tid : rr_ptr;
                sel_ok  = arb_hit;
            end
        endcase
    end

    assign issue_valid  = sel_ok;
    assign issue_bubble = ~sel_ok;
    assign issue_tid    = sel_tid;

    mt_slot_table #(
        .NTHR  (NTHR),
        .NSLOT (NSLOT)
    ) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_slot (tbl_wr_slot),
        .wr_tid  (tbl_wr_tid),
        .commit  (slot_wrap),
        .rd_slot (slot_idx),
        .rd_tid  (tbl_tid)
    );

    mt_ready_arb #(
        .NTHR (NTHR)
    ) u_arb (
        .req       (thr_ready),
        .start     (rr_ptr),
        .hit       (arb_hit),
        .grant_tid (arb_tid)
    );

    mt_tag_pipe #(
        .NTHR   (NTHR),
        .NSTAGE (NSTAGE)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (issue_valid),
        .in_tid    (issue_tid),
        .stage_vld (stage_vld),
        .stage_tid (stage_tid)
    );

endmodule

// File: rtl/mt_issue_sched_chk.sv
module mt_issue_sched_chk #(
    parameter int NTHR   = 4,
    parameter int NSLOT  = 8,
    parameter int NSTAGE = 5,
    localparam int TID_W  = (NTHR  > 1) ? $clog2(NTHR)  : 1,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NTHR-1:0]         thr_ready,
    input logic                    issue_valid,
    input logic [TID_W-1:0]        issue_tid,
    input logic                    issue_bubble,
    input logic [NSTAGE-1:0]       stage_vld,
    input logic [NSTAGE*TID_W-1:0] stage_tid,
    input logic [1:0]              cur_state,
    input logic [SLOT_W-1:0]       slot_idx,
    input logic                    slot_wrap
);

    localparam logic [1:0] ST_FIXED = 2'd0;
    localparam logic [1:0] ST_TABLE = 2'd1;
    localparam logic [1:0] ST_READY = 2'd2;

    logic             past_ok;
    logic [TID_W-1:0] tid_d1;
    logic [TID_W-1:0] tid_d1_inc;

    always_ff @(posedge clk) begin
        past_ok <= !rst;
        tid_d1  <= issue_tid;
    end

    assign tid_d1_inc = (tid_d1 == TID_W'(NTHR - 1)) ? '0 : tid_d1 + TID_W'(1);

    p_fixed_step_r1: assert property (@(posedge clk) disable iff (rst)
        (past_ok && cur_state == ST_FIXED && $past(cur_state) == ST_FIXED)
            |-> issue_tid == tid_d1_inc);

    p_owner_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_FIXED || cur_state == ST_TABLE) |-> issue_valid == thr_ready[issue_tid]);

    p_slot_step_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(slot_wrap)) |-> slot_idx == $past(slot_idx) + SLOT_W'(1));

    p_slot_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(slot_wrap)) |-> slot_idx == '0);

    p_ready_any_r4: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_READY) |-> issue_valid == (|thr_ready));

    p_ready_pick_r4: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_READY && issue_valid) |-> thr_ready[issue_tid]);

    p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(slot_wrap)) |-> $stable(cur_state));

    p_tag_head_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (stage_vld[0] == $past(issue_valid)
                     && stage_tid[TID_W-1:0] == $past(issue_tid)));

    genvar k;
    generate
        for (k = 1; k < NSTAGE; k++) begin : g_tag
            p_tag_shift_r6: assert property (@(posedge clk) disable iff (rst)
                past_ok |-> (stage_vld[k] == $past(stage_vld[k-1])
                             && stage_tid[k*TID_W +: TID_W] == $past(stage_tid[(k-1)*TID_W +: TID_W])));
        end
    endgenerate

    p_reset_clear_r7: assert property (@(posedge clk)
        $past(rst) |-> (stage_vld == '0 && slot_idx == '0 && cur_state == ST_FIXED));

    p_bubble_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $countones({issue_valid, issue_bubble}) == 1);

    generate
        if (NTHR > 1) begin : g_norep
            p_no_repeat_r9: assert property (@(posedge clk) disable iff (rst)
                (past_ok && cur_state == ST_FIXED && $past(cur_state) == ST_FIXED
                 && issue_valid && stage_vld[0])
                    |-> issue_tid != stage_tid[TID_W-1:0]);
        end
    endgenerate

endmodule

bind mt_issue_sched mt_issue_sched_chk #(
    .NTHR   (NTHR),
    .NSLOT  (NSLOT),
    .NSTAGE (NSTAGE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .thr_ready    (thr_ready),
    .issue_valid  (issue_valid),
    .issue_tid    (issue_tid),
    .issue_bubble (issue_bubble),
    .stage_vld    (stage_vld),
    .stage_tid    (stage_tid),
    .cur_state    (cur_state),
    .slot_idx     (slot_idx),
    .slot_wrap    (slot_wrap)
);

// File: tb/mt_issue_sched_bench.sv
module mt_issue_sched_bench;

    localparam int NTHR   = 4;
    localparam int NSLOT  = 8;
    localparam int NSTAGE = 5;
    localparam int TID_W  = 2;
    localparam int SLOT_W = 3;
    localparam int NROWS  = 24;

    // Row fields: mode[14:13] ready[12:9] we[8] addr[7:5] data[4:3] exp_valid[2] exp_tid[1:0]
    localparam logic [14:0] VECS [0:NROWS-1] = '{
        {2'd1, 4'b1111, 1'b1, 3'd0, 2'd3, 1'b1, 2'd0},
        {2'd1, 4'b0000, 1'b1, 3'd1, 2'd1, 1'b0, 2'd1},
        {2'd1, 4'b1011, 1'b1, 3'd2, 2'd1, 1'b0, 2'd2},
        {2'd1, 4'b1000, 1'b1, 3'd3, 2'd0, 1'b1, 2'd3},
        {2'd1, 4'b0001, 1'b1, 3'd4, 2'd2, 1'b1, 2'd0},
        {2'd1, 4'b1101, 1'b1, 3'd5, 2'd2, 1'b0, 2'd1},
        {2'd1, 4'b0100, 1'b1, 3'd6, 2'd0, 1'b1, 2'd2},
        {2'd1, 4'b1111, 1'b1, 3'd7, 2'd3, 1'b1, 2'd3},
        {2'd2, 4'b1000, 1'b0, 3'd0, 2'd0, 1'b1, 2'd3},
        {2'd2, 4'b0001, 1'b1, 3'd5, 2'd1, 1'b0, 2'd1},
        {2'd2, 4'b0010, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1},
        {2'd2, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd0},
        {2'd2, 4'b0100, 1'b0, 3'd0, 2'd0, 1'b1, 2'd2},
        {2'd2, 4'b0100, 1'b0, 3'd0, 2'd0, 1'b1, 2'd2},
        {2'd2, 4'b1110, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0},
        {2'd2, 4'b1000, 1'b0, 3'd0, 2'd0, 1'b1, 2'd3},
        {2'd0, 4'b0110, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1},
        {2'd0, 4'b0010, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1},
        {2'd0, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd2},
        {2'd0, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd3},
        {2'd0, 4'b0000, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0},
        {2'd0, 4'b1001, 1'b0, 3'd0, 2'd0, 1'b1, 2'd0},
        {2'd0, 4'b1001, 1'b0, 3'd0, 2'd0, 1'b1, 2'd3},
        {2'd0, 4'b0100, 1'b0, 3'd0, 2'd0, 1'b1, 2'd2}
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [NTHR-1:0]         thr_ready = '0;
    logic [1:0]              mode_req = 2'd0;
    logic                    tbl_wr_en = 1'b0;
    logic [SLOT_W-1:0]       tbl_wr_slot = '0;
    logic [TID_W-1:0]        tbl_wr_tid = '0;
    logic                    issue_valid;
    logic [TID_W-1:0]        issue_tid;
    logic                    issue_bubble;
    logic [NSTAGE-1:0]       stage_vld;
    logic [NSTAGE*TID_W-1:0] stage_tid;

    int  ntests = 0;
    int  nfail  = 0;
    bit  done   = 1'b0;
    bit  hv [0:63];
    int  ht [0:63];

    always #5 clk = ~clk;

    mt_issue_sched #(
        .NTHR   (NTHR),
        .NSLOT  (NSLOT),
        .NSTAGE (NSTAGE)
    ) u_mt_issue_sched (
        .clk          (clk),
        .rst          (rst),
        .thr_ready    (thr_ready),
        .mode_req     (mode_req),
        .tbl_wr_en    (tbl_wr_en),
        .tbl_wr_slot  (tbl_wr_slot),
        .tbl_wr_tid   (tbl_wr_tid),
        .issue_valid  (issue_valid),
        .issue_tid    (issue_tid),
        .issue_bubble (issue_bubble),
        .stage_vld    (stage_vld),
        .stage_tid    (stage_tid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_issue(input string req, input int cyc, input bit ev, input int et);
        check(issue_valid == ev, req, $sformatf("valid at cycle %0d", cyc), int'(issue_valid), int'(ev));
        check(int'(issue_tid) == et, req, $sformatf("thread at cycle %0d", cyc), int'(issue_tid), et);
        check(issue_bubble == !ev, "R8", $sformatf("bubble at cycle %0d", cyc), int'(issue_bubble), int'(!ev));
    endtask

    // R6: stage k shows the issue of cycle cyc-1-k
    task automatic check_stages(input int cyc);
        logic [NSTAGE-1:0]       ev;
        logic [NSTAGE*TID_W-1:0] et;
        ev = '0;
        et = '0;
        for (int k = 0; k < NSTAGE; k++) begin
            if (cyc - 1 - k >= 0) begin
                ev[k]                 = hv[cyc-1-k];
                et[k*TID_W +: TID_W] = TID_W'(ht[cyc-1-k]);
            end
        end
        check(stage_vld == ev, "R6", $sformatf("stage valids at cycle %0d", cyc), int'(stage_vld), int'(ev));
        check(stage_tid == et, "R6", $sformatf("stage threads at cycle %0d", cyc), int'(stage_tid), int'(et));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nfail++;
            ntests++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            finish_run();
        end
    end

    initial begin
        // Reset state (R7): rotation at thread 0, stages empty
        thr_ready = 4'b0010;
        mode_req  = 2'd0;
        do_reset();
        #4;
        check(issue_tid == 2'd0, "R7", "thread after reset", int'(issue_tid), 0);
        check(issue_valid == 1'b0, "R7", "valid after reset with thread 0 idle", int'(issue_valid), 0);
        check(stage_vld == '0, "R7", "stages after reset", int'(stage_vld), 0);
        check(issue_bubble == 1'b1, "R8", "bubble after reset", int'(issue_bubble), 1);

        // Table walk: fixed (R1,R2,R5), table (R3,R5), ready (R4)
        do_reset();
        for (int c = 0; c < NROWS; c++) begin
            logic [14:0] v;
            string       req;
            v           = VECS[c];
            mode_req    = v[14:13];
            thr_ready   = v[12:9];
            tbl_wr_en   = v[8];
            tbl_wr_slot = v[7:5];
            tbl_wr_tid  = v[4:3];
            hv[c]       = v[2];
            ht[c]       = int'(v[1:0]);
            #4;
            if (c < 8)       req = "R1/R2/R5";
            else if (c < 16) req = "R3/R2/R5";
            else             req = "R4";
            check_issue(req, c, v[2], int'(v[1:0]));
            check_stages(c);
            next_cycle();
        end

        // Return to rotation at cycle 24: restarts at thread 0 (R1), no repeat (R9)
        tbl_wr_en = 1'b0;
        mode_req  = 2'd0;
        thr_ready = 4'b1111;
        for (int c = NROWS; c < NROWS + 8; c++) begin
            hv[c] = 1'b1;
            ht[c] = c % NTHR;
            #4;
            check_issue("R1", c, 1'b1, c % NTHR);
            check_stages(c);
            if (c >= NROWS + NTHR - 1) begin
                bit clash;
                clash = 1'b0;
                for (int k = 0; k < NTHR - 1; k++) begin
                    if (stage_vld[k] && stage_tid[k*TID_W +: TID_W] == issue_tid) clash = 1'b1;
                end
                check(!clash, "R9", $sformatf("repeat within window at cycle %0d", c), int'(clash), 0);
            end
            next_cycle();
        end

        // Enter ready mode, then reset in the middle of it (R7)
        mode_req = 2'd2;
        for (int c = 0; c < 10; c++) next_cycle();
        thr_ready = 4'b0100;
        #4;
        check(issue_valid == 1'b1 && issue_tid == 2'd2, "R4", "grant before mid-run reset",
              int'(issue_tid), 2);
        mode_req = 2'd1;
        do_reset();
        #4;
        check(issue_tid == 2'd0 && issue_valid == 1'b0, "R7", "rotation restarted by reset",
              int'(issue_tid), 0);
        check(stage_vld == '0, "R7", "stages cleared by reset", int'(stage_vld), 0);
        next_cycle();
        thr_ready = 4'b1111;
        for (int c = 1; c < 8; c++) begin
            #4;
            check(int'(issue_tid) == c % NTHR, "R5", $sformatf("table request held, cycle %0d", c),
                  int'(issue_tid), c % NTHR);
            next_cycle();
        end
        // Table entries were cleared by reset (R7); request code 3 queued for next wrap
        mode_req = 2'd3;
        for (int c = 8; c < 16; c++) begin
            #4;
            check(issue_tid == 2'd0 && issue_valid, "R7", $sformatf("cleared table slot %0d", c - 8),
                  int'(issue_tid), 0);
            next_cycle();
        end
        // Code 3 behaves as rotation starting at thread 0 (R1)
        for (int c = 16; c < 20; c++) begin
            #4;
            check(int'(issue_tid) == c - 16, "R1", $sformatf("code 3 rotation at cycle %0d", c),
                  int'(issue_tid), c - 16);
            next_cycle();
        end

        finish_run();
    end

endmodule